// File: doc/BRIEF.md
# ModR/M and SIB Effective Address Generator

This block turns the already-decoded addressing fields of an instruction into an effective offset. It takes the two-bit mode field, the three-bit register/memory field, the scale, index and base fields of a scaled-index byte, and a raw displacement word. It also takes an address-size flag and an optional segment override. Two combinational read ports fetch the base and index registers from an eight-entry 32-bit register file outside the block.

The block returns four things: the offset, a segment code (the default for the addressing form, or the override), a flag that marks a register operand, and the register number in that case. Results are registered with one cycle of latency and a valid bit, and a new operand may be presented every cycle. Adding the segment base, limit checking and paging are left to later stages.

Register numbers on the read ports are 0 to 7 for AX/EAX, CX/ECX, DX/EDX, BX/EBX, SP/ESP, BP/EBP, SI/ESI and DI/EDI. Segment codes are ES=0, CS=1, SS=2, DS=3, FS=4 and GS=5.

Top module: `modrm_agu`

## Requirements
- R1: One clock edge after reset is released, out_valid is 0 and out_ea is 0. Each cycle with in_valid=1 gives one result with out_valid=1 on the next cycle, in input order, with no gap when inputs arrive back to back. Each cycle with in_valid=0 gives out_valid=0 on the next cycle.
- R2: When mod=11 the result has out_is_reg=1, out_ea=0 and out_reg_num equal to rm, and no memory address is formed. For every other mod, out_is_reg=0 and out_reg_num=0.
- R3: With in_addr32=0 and mod other than 11, rm 000 to 111 form BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX, using the low 16 bits of each register. The combination mod=00 with rm=110 uses in_disp[15:0] alone, with no register.
- R4: In 16-bit mode the displacement is zero for mod=00 (except the case rm=110), in_disp[7:0] sign-extended for mod=01, and in_disp[15:0] for mod=10. The sum wraps modulo 2^16 and out_ea[31:16] is 0.
- R5: In 16-bit mode with no override, rm=010, rm=011, and rm=110 with a mod other than 00 give SS (2). Every other memory form gives DS (3), including the disp16-only form.
- R6: With in_addr32=1 and rm other than 100, the base register is the register numbered rm. The combination mod=00 with rm=101 gives in_disp alone. The displacement is zero for mod=00, in_disp[7:0] sign-extended for mod=01, and the full in_disp for mod=10.
- R7: In 32-bit mode with no override and rm other than 100, forms with EBP as base (rm=101 with a mod other than 00) give SS. All other forms, including the disp32-only form, give DS.
- R8: With in_addr32=1 and rm=100, the offset is base + (index << scale), plus the displacement for the current mod, modulo 2^32. Scale 0 to 3 multiplies by 1, 2, 4 and 8.
- R9: An index field of 100 adds no index term, whatever the scale.
- R10: A base field of 100 (ESP) defaults to SS. A base field of 101 with mod=00 adds no base register, adds the full in_disp, and defaults to DS. A base field of 101 with any other mod uses EBP and defaults to SS. Other base fields default to DS.
- R11: When in_ovr_valid=1, out_seg equals in_ovr_seg in place of the default, for every form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand fields valid this cycle |
| in_addr32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit addressing |
| in_mod | input | 2 | Mode field |
| in_rm | input | 3 | Register/memory field |
| in_scale | input | 2 | Scaled-index byte: scale |
| in_index | input | 3 | Scaled-index byte: index register |
| in_base | input | 3 | Scaled-index byte: base register |
| in_disp | input | 32 | Raw displacement (the block picks 8, 16 or 32 bits) |
| in_ovr_valid | input | 1 | Segment override present |
| in_ovr_seg | input | 3 | Override segment code |
| rd_a_sel | output | 3 | Base register read select |
| rd_a_data | input | 32 | Base register read data |
| rd_b_sel | output | 3 | Index register read select |
| rd_b_data | input | 32 | Index register read data |
| out_valid | output | 1 | Result valid |
| out_ea | output | 32 | Effective offset |
| out_seg | output | 3 | Selected segment code |
| out_is_reg | output | 1 | Operand is a register, not memory |
| out_reg_num | output | 3 | Register number when out_is_reg=1 |

## Verification
The segment choice has two sources that meet in the same cycle: the default implied by the addressing form and an override presented with the operand. The bench sends overrides on forms whose default is SS, and on the disp-only forms whose default is DS. It expects the override code in every such case, and the default again on the next operand, which has no override. Operands are also sent back to back, so the capture of a new operand falls in the cycle where the previous result is presented. The scoreboard judges that overlap by requiring results in input order with no skipped or extra valid cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;
   localparam int AGU_AW   = 32;
   localparam int AGU_NREG = 8;
   localparam int AGU_SELW = 3;

   typedef enum logic [2:0] {
      SEG_ES = 3'd0, SEG_CS = 3'd1, SEG_SS = 3'd2,
      SEG_DS = 3'd3, SEG_FS = 3'd4, SEG_GS = 3'd5
   } seg_e;

   localparam logic [AGU_SELW-1:0] GPR_BX = 3'd3;
   localparam logic [AGU_SELW-1:0] GPR_SP = 3'd4;
   localparam logic [AGU_SELW-1:0] GPR_BP = 3'd5;
   localparam logic [AGU_SELW-1:0] GPR_SI = 3'd6;
   localparam logic [AGU_SELW-1:0] GPR_DI = 3'd7;

   typedef struct packed {
      logic [AGU_SELW-1:0] sel_a;
      logic [AGU_SELW-1:0] sel_b;
      logic                use_a;
      logic                use_b;
      logic [1:0]          shift;
      logic [AGU_AW-1:0]   disp;
      seg_e                seg;
      logic                is_reg;
      logic                wrap16;
   } agu_ctl_t;
endpackage

// File: rtl/agu_dec16.sv
module agu_dec16
   import agu_pkg::*;
(
   input  logic [1:0]  mode,
   input  logic [2:0]  rm,
   input  logic [15:0] disp16,
   output agu_ctl_t    ctl
);
   always_comb begin
      ctl        = '0;
      ctl.seg    = SEG_DS;
      ctl.wrap16 = 1'b1;
      ctl.is_reg = (mode == 2'b11);
      ctl.use_a  = 1'b1;
      case (rm)
         3'd0: begin ctl.sel_a = GPR_BX; ctl.sel_b = GPR_SI; ctl.use_b = 1'b1; end
         3'd1: begin ctl.sel_a = GPR_BX; ctl.sel_b = GPR_DI; ctl.use_b = 1'b1; end
         3'd2: begin ctl.sel_a = GPR_BP; ctl.sel_b = GPR_SI; ctl.use_b = 1'b1; end
         3'd3: begin ctl.sel_a = GPR_BP; ctl.sel_b = GPR_DI; ctl.use_b = 1'b1; end
         3'd4: ctl.sel_a = GPR_SI;
         3'd5: ctl.sel_a = GPR_DI;
         3'd6: ctl.sel_a = GPR_BP;
         default: ctl.sel_a = GPR_BX;
      endcase
      if (rm == 3'd2 || rm == 3'd3 || (rm == 3'd6 && mode != 2'b00))
         ctl.seg = SEG_SS;
      case (mode)
         2'b01:   ctl.disp = {{(AGU_AW-8){disp16[7]}}, disp16[7:0]};
         2'b10:   ctl.disp = {{(AGU_AW-16){1'b0}}, disp16};
         default: ctl.disp = '0;
      endcase
      if (mode == 2'b00 && rm == 3'd6) begin
         ctl.use_a = 1'b0;
         ctl.disp  = {{(AGU_AW-16){1'b0}}, disp16};
      end
      if (ctl.is_reg) begin
         ctl.use_a = 1'b0;
         ctl.use_b = 1'b0;
         ctl.disp  = '0;
         ctl.seg   = SEG_DS;
      end
   end
endmodule

// File: rtl/agu_dec32.sv
module agu_dec32
   import agu_pkg::*;
(
   input  logic [1:0]        mode,
   input  logic [2:0]        rm,
   input  logic [1:0]        scale,
   input  logic [2:0]        index,
   input  logic [2:0]        base,
   input  logic [AGU_AW-1:0] disp,
   output agu_ctl_t          ctl
);
   logic sib, no_base, ss_base;

   always_comb begin
      ctl        = '0;
      ctl.seg    = SEG_DS;
      ctl.is_reg = (mode == 2'b11);
      sib        = (rm == GPR_SP);
      ctl.sel_a  = sib ? base : rm;
      ctl.sel_b  = index;
      ctl.shift  = scale;
      ctl.use_b  = sib && (index != GPR_SP);
      no_base    = (mode == 2'b00) && (ctl.sel_a == GPR_BP);
      ss_base    = (ctl.sel_a == GPR_BP) || (sib && base == GPR_SP);
      ctl.use_a  = !no_base;
      if (ss_base && !no_base)
         ctl.seg = SEG_SS;
      case (mode)
         2'b01:   ctl.disp = {{(AGU_AW-8){disp[7]}}, disp[7:0]};
         2'b10:   ctl.disp = disp;
         default: ctl.disp = no_base ? disp : '0;
      endcase
      if (ctl.is_reg) begin
         ctl.use_a = 1'b0;
         ctl.use_b = 1'b0;
         ctl.disp  = '0;
         ctl.seg   = SEG_DS;
      end
   end
endmodule

// File: rtl/agu_sum.sv
module agu_sum #(
   parameter int AW  = 32,
   parameter int SHW = 2
) (
   input  logic [AW-1:0]  base_val,
   input  logic [AW-1:0]  index_val,
   input  logic [AW-1:0]  disp,
   input  logic           use_base,
   input  logic           use_index,
   input  logic [SHW-1:0] shift,
   input  logic           wrap16,
   output logic [AW-1:0]  ea
);
   logic [AW-1:0] base_t, index_t, raw;

   assign base_t  = use_base  ? base_val : '0;
   assign index_t = use_index ? (index_val << shift) : '0;
   assign raw     = base_t + index_t + disp;
   assign ea      = wrap16 ? {{(AW-16){1'b0}}, raw[15:0]} : raw;
endmodule

// File: rtl/modrm_agu.sv
module modrm_agu
   import agu_pkg::*;
#(
   parameter int AW    = 32,
   parameter int NREG  = 8,
   parameter int SEGW  = 3,
   parameter bit EN_16 = 1'b1,
   localparam int SELW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_addr32,
   input  logic [1:0]      in_mod,
   input  logic [2:0]      in_rm,
   input  logic [1:0]      in_scale,
   input  logic [2:0]      in_index,
   input  logic [2:0]      in_base,
   input  logic [AW-1:0]   in_disp,
   input  logic            in_ovr_valid,
   input  logic [SEGW-1:0] in_ovr_seg,
   output logic [SELW-1:0] rd_a_sel,
   input  logic [AW-1:0]   rd_a_data,
   output logic [SELW-1:0] rd_b_sel,
   input  logic [AW-1:0]   rd_b_data,
   output logic            out_valid,
   output logic [AW-1:0]   out_ea,
   output logic [SEGW-1:0] out_seg,
   output logic            out_is_reg,
   output logic [SELW-1:0] out_reg_num
);
   if (AW != AGU_AW)     begin : g_bad_aw   $error("AW must match AGU_AW"); end
   if (NREG != AGU_NREG) begin : g_bad_nreg $error("NREG must be 8"); end
   if (SEGW != 3)        begin : g_bad_segw $error("SEGW must be 3"); end

   agu_ctl_t ctl16, ctl32, ctl;
   logic     use16;
   logic [AW-1:0] ea_c;
   logic [SEGW-1:0] seg_c;

   agu_dec32 u_dec32 (
      .mode(in_mod), .rm(in_rm), .scale(in_scale), .index(in_index),
      .base(in_base), .disp(in_disp), .ctl(ctl32)
   );

   if (EN_16) begin : g_with16
      agu_dec16 u_dec16 (
         .mode(in_mod), .rm(in_rm), .disp16(in_disp[15:0]), .ctl(ctl16)
      );
      assign use16 = !in_addr32;
   end else begin : g_no16
      assign ctl16 = '0;
      assign use16 = 1'b0;
   end

   assign ctl      = use16 ? ctl16 : ctl32;
   assign rd_a_sel = ctl.sel_a;
   assign rd_b_sel = ctl.sel_b;

   agu_sum #(.AW(AW), .SHW(2)) u_sum (
      .base_val(rd_a_data), .index_val(rd_b_data), .disp(ctl.disp),
      .use_base(ctl.use_a), .use_index(ctl.use_b), .shift(ctl.shift),
      .wrap16(ctl.wrap16), .ea(ea_c)
   );

   assign seg_c = in_ovr_valid ? in_ovr_seg : SEGW'(ctl.seg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_ea      <= '0;
         out_seg     <= '0;
         out_is_reg  <= 1'b0;
         out_reg_num <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_ea      <= ea_c;
            out_seg     <= seg_c;
            out_is_reg  <= ctl.is_reg;
            out_reg_num <= ctl.is_reg ? in_rm : '0;
         end
      end
   end
endmodule

// File: rtl/modrm_agu_chk.sv
module modrm_agu_chk #(
   parameter int AW    = 32,
   parameter bit EN_16 = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_addr32,
   input logic [1:0]    in_mod,
   input logic [2:0]    in_rm,
   input logic [2:0]    in_index,
   input logic [2:0]    in_base,
   input logic [AW-1:0] in_disp,
   input logic          in_ovr_valid,
   input logic [2:0]    in_ovr_seg,
   input logic          out_valid,
   input logic [AW-1:0] out_ea,
   input logic [2:0]    out_seg,
   input logic          out_is_reg,
   input logic [2:0]    out_reg_num
);
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_reg_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mod == 2'b11) |=>
         (out_is_reg && out_ea == '0 && out_reg_num == $past(in_rm)));
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (EN_16 && in_valid && !in_addr32) |=> (out_ea[AW-1:16] == '0));
   p_ss16_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (EN_16 && in_valid && !in_addr32 && in_mod != 2'b11 && !in_ovr_valid &&
       (in_rm == 3'd2 || in_rm == 3'd3)) |=> (out_seg == 3'd2));
   p_disp32_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_addr32 || !EN_16) && in_mod == 2'b00 && in_rm == 3'd5 &&
       !in_ovr_valid) |=> (out_ea == $past(in_disp) && out_seg == 3'd3));
   p_sib_disp_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_addr32 || !EN_16) && in_mod == 2'b00 && in_rm == 3'd4 &&
       in_index == 3'd4 && in_base == 3'd5) |=> (out_ea == $past(in_disp)));
   p_override_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ovr_valid) |=> (out_seg == $past(in_ovr_seg)));
endmodule

bind modrm_agu modrm_agu_chk #(.AW(AW), .EN_16(EN_16)) u_chk (.*);

// File: tb/modrm_agu_bench.sv
module modrm_agu_bench;
   typedef struct {
      logic [31:0] ea;
      logic [2:0]  seg;
      logic        is_reg;
      logic [2:0]  reg_num;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_addr32 = 1'b0, in_ovr_valid = 1'b0;
   logic [1:0]  in_mod = '0, in_scale = '0;
   logic [2:0]  in_rm = '0, in_index = '0, in_base = '0, in_ovr_seg = '0;
   logic [31:0] in_disp = '0;
   logic [2:0]  rd_a_sel, rd_b_sel, out_seg, out_reg_num;
   logic [31:0] rd_a_data, rd_b_data, out_ea;
   logic        out_valid, out_is_reg;
   logic [31:0] rf [8];
   exp_t        q[$];
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   assign rd_a_data = rf[rd_a_sel];
   assign rd_b_data = rf[rd_b_sel];

   modrm_agu u_modrm_agu (.*);

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(bit a32, logic [1:0] md, logic [2:0] rm,
                                  logic [1:0] sc, logic [2:0] ix, logic [2:0] bs,
                                  logic [31:0] d, bit ovv, logic [2:0] ov);
      exp_t e;
      logic [31:0] sx8, dd, b, x;
      sx8 = {{24{d[7]}}, d[7:0]};
      e.seg = 3'd3; e.is_reg = 1'b0; e.reg_num = 3'd0; e.ea = 32'd0;
      if (md == 2'b11) begin
         e.is_reg = 1'b1; e.reg_num = rm;
      end else if (!a32) begin
         dd = (md == 2'b01) ? sx8 : (md == 2'b10) ? {16'd0, d[15:0]} : 32'd0;
         case (rm)
            3'd0: b = rf[3] + rf[6];
            3'd1: b = rf[3] + rf[7];
            3'd2: b = rf[5] + rf[6];
            3'd3: b = rf[5] + rf[7];
            3'd4: b = rf[6];
            3'd5: b = rf[7];
            3'd6: b = (md == 2'b00) ? 32'd0 : rf[5];
            default: b = rf[3];
         endcase
         if (md == 2'b00 && rm == 3'd6) dd = {16'd0, d[15:0]};
         e.ea = {16'd0, 16'(b + dd)};
         if (rm == 3'd2 || rm == 3'd3 || (rm == 3'd6 && md != 2'b00)) e.seg = 3'd2;
      end else begin
         dd = (md == 2'b01) ? sx8 : (md == 2'b10) ? d : 32'd0;
         if (rm != 3'd4) begin
            if (md == 2'b00 && rm == 3'd5) begin b = 0; dd = d; end
            else b = rf[rm];
            if (rm == 3'd5 && md != 2'b00) e.seg = 3'd2;
            x = 0;
         end else begin
            x = (ix == 3'd4) ? 32'd0 : (rf[ix] << sc);
            if (bs == 3'd5 && md == 2'b00) begin b = 0; dd = d; end
            else begin
               b = rf[bs];
               if (bs == 3'd4 || bs == 3'd5) e.seg = 3'd2;
            end
         end
         e.ea = b + x + dd;
      end
      if (ovv) e.seg = ov;
      return e;
   endfunction

   task automatic drive(bit a32, logic [1:0] md, logic [2:0] rm, logic [1:0] sc,
                        logic [2:0] ix, logic [2:0] bs, logic [31:0] d,
                        bit ovv, logic [2:0] ov, string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1; in_addr32 = a32; in_mod = md; in_rm = rm; in_scale = sc;
      in_index = ix; in_base = bs; in_disp = d; in_ovr_valid = ovv; in_ovr_seg = ov;
      e = model(a32, md, rm, sc, ix, bs, d, ovv, ov);
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(int n);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   // Monitor: pops one expected item per valid result
   always @(posedge clk) begin
      #1;
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            check("R1", "unexpected out_valid", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "ea", out_ea, e.ea);
            check(e.tag, "seg", {29'd0, out_seg}, {29'd0, e.seg});
            check(e.tag, "is_reg/reg_num", {28'd0, out_is_reg, out_reg_num},
                  {28'd0, e.is_reg, e.reg_num});
         end
      end
   end

   initial begin
      rf[0] = 32'h1000_0010; rf[1] = 32'h0000_0230; rf[2] = 32'h8000_0004;
      rf[3] = 32'h0012_FFF0; rf[4] = 32'h0000_7F00; rf[5] = 32'h00AB_8001;
      rf[6] = 32'h0001_0024; rf[7] = 32'hFFFF_9000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      // R1: reset state
      check("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
      check("R1", "reset out_ea", out_ea, 32'd0);

      // R2: register operand forms in both sizes
      drive(0, 2'b11, 3'd5, 0, 0, 0, 32'h1234_5678, 0, 0, "R2");
      drive(1, 2'b11, 3'd2, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, "R2");
      // R3/R5: 16-bit mod 00, disp ignored except rm 110
      for (int r = 0; r < 8; r++)
         drive(0, 2'b00, 3'(r), 0, 0, 0, 32'hABCD_5678, 0, 0, "R3");
      // R4/R5: 16-bit negative and positive disp8, disp16 with wrap
      for (int r = 0; r < 8; r++)
         drive(0, 2'b01, 3'(r), 0, 0, 0, 32'h0000_0080, 0, 0, "R4");
      for (int r = 0; r < 8; r++)
         drive(0, 2'b01, 3'(r), 0, 0, 0, 32'h0000_007F, 0, 0, "R5");
      for (int r = 0; r < 8; r++)
         drive(0, 2'b10, 3'(r), 0, 0, 0, 32'h7777_F123, 0, 0, "R4");
      // R6/R7: 32-bit direct base forms
      for (int m = 0; m < 3; m++)
         for (int r = 0; r < 8; r++)
            if (r != 4)
               drive(1, 2'(m), 3'(r), 0, 0, 0, 32'h8000_00F0, 0, 0, (r == 5) ? "R7" : "R6");
      idle(3);
      check("R1", "idle out_valid", {31'd0, out_valid}, 32'd0);
      // R8: scaled index
      for (int s = 0; s < 4; s++)
         for (int m = 0; m < 3; m++)
            drive(1, 2'(m), 3'd4, 2'(s), 3'(s + 1), 3'd0, 32'h0000_0188, 0, 0, "R8");
      drive(1, 2'b10, 3'd4, 2'd3, 3'd7, 3'd6, 32'h0101_0101, 0, 0, "R8");
      // R9: index 100 means none
      for (int s = 0; s < 4; s++)
         drive(1, 2'b01, 3'd4, 2'(s), 3'd4, 3'd1, 32'h0000_00FE, 0, 0, "R9");
      drive(1, 2'b00, 3'd4, 2'd2, 3'd4, 3'd5, 32'hDEAD_0000, 0, 0, "R9");
      // R10: base 100 and base 101 special cases
      for (int m = 0; m < 3; m++) begin
         drive(1, 2'(m), 3'd4, 2'd1, 3'd2, 3'd4, 32'h0000_0010, 0, 0, "R10");
         drive(1, 2'(m), 3'd4, 2'd1, 3'd2, 3'd5, 32'h0000_0010, 0, 0, "R10");
      end
      drive(1, 2'b00, 3'd4, 2'd0, 3'd5, 3'd3, 32'h0000_0000, 0, 0, "R10");
      // R11: override against SS defaults and disp-only forms, then default again
      drive(0, 2'b01, 3'd2, 0, 0, 0, 32'h0000_0001, 1, 3'd4, "R11");
      drive(0, 2'b01, 3'd2, 0, 0, 0, 32'h0000_0001, 0, 3'd4, "R11");
      drive(0, 2'b00, 3'd6, 0, 0, 0, 32'h0000_4444, 1, 3'd0, "R11");
      drive(1, 2'b10, 3'd5, 0, 0, 0, 32'h0000_0100, 1, 3'd1, "R11");
      drive(1, 2'b00, 3'd5, 0, 0, 0, 32'h0000_0100, 1, 3'd5, "R11");
      drive(1, 2'b01, 3'd4, 2'd0, 3'd4, 3'd4, 32'h0000_0001, 1, 3'd3, "R11");
      drive(1, 2'b01, 3'd4, 2'd0, 3'd4, 3'd4, 32'h0000_0001, 0, 3'd3, "R11");
      drive(1, 2'b11, 3'd1, 0, 0, 0, 32'h0, 1, 3'd2, "R11");
      idle(4);
      check("R1", "all results delivered", q.size(), 32'd0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule